// File: doc/BRIEF.md
# SPI Serial Byte Memory Target with Hold

This block is a synchronous model of a small serial byte memory that answers as an SPI mode-0 target. A host opens a transaction by pulling the chip select low, shifts in an 8-bit command and, for array access, a 9-bit byte address, then streams data. The address counter advances after every data byte, so a burst can run over the whole array and wrap. A write-enable latch must be armed before the array or the status register accepts new content. A separate protect input refuses all writes while it is low.

The serial pins are not used as clocks. The serial clock, chip select, hold, data-in and protect inputs are passed through synchronizers in the system clock domain, and the block acts on the edges it detects there. The serial output is presented as a registered data bit and a registered output enable, so a pad or a shared data line can be driven outside the block. A hold input lets the host pause a transfer halfway through a byte and resume it later with nothing lost.

Top module: `spi_nvmem_target`

## Requirements
- R1: A command is decoded only from the first 8 bits after a chip-select falling edge, sent MSB first. A byte that is not one of the six commands below causes no read or write for the rest of that selection.
- R2: Input data is taken on rising serial-clock edges. Output data changes only after falling serial-clock edges, MSB first, so the first read bit is valid before the first rising edge of the data byte.
- R3: READ is 0x03 with address bit 8 carried in command bit 3 (0x0B for the upper half), followed by the low address byte. Data bytes from incrementing addresses follow, and the address wraps from 511 to 0.
- R4: WRITE is 0x02 or 0x0A, using the same address layout as READ. Each complete data byte is stored at the current address, which then increments and wraps. A byte left incomplete when chip select rises is dropped.
- R5: WREN (0x06) sets the write-enable latch. Array and status writes are refused while the latch is clear. The latch clears at the chip-select rising edge that ends a selection in which WRDI (0x04) was received, a WRITE data byte completed, or a WRSR byte completed.
- R6: RDSR (0x05) returns the status byte repeatedly: bit 1 is the write-enable latch, bits 4..2 are three retained bits, and all other bits read 0. WRSR (0x01) followed by one byte loads bits 4..2 of that byte into the retained bits.
- R7: While the protect input is low, both array writes and status-register writes are refused.
- R8: While hold is low during a selection, serial-clock edges and chip-select changes are ignored and the bit, byte and address state is kept. The transfer continues after hold returns high.
- R9: A hold edge seen while the serial clock is high during a selection raises the error output for one system clock and does not change the hold state.
- R10: The output enable is high only while read or status data is being shifted out. It is low while deselected, during hold, and during commands that return no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Transfer pause, active low |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data bit to the host |
| so_oe | output | 1 | Output enable for so |
| hold_err | output | 1 | One-cycle pulse on a hold edge while the serial clock is high |

## Verification
The hardest case to reach from the ports is a hold that falls in the middle of a read byte while chip select is also toggled and extra clock pulses arrive. The bench stops after four bits of a read data byte with the clock low and lowers hold. It then pulses the serial clock, raises and lowers chip select, and releases hold. It checks that the enable dropped during the pause, that the remaining four bits complete the correct byte, and that the next byte comes from the next address. A second case raises the clock partway through a command byte and pulses hold while the clock is high. The command must still decode correctly and the error output must show exactly two one-cycle pulses.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam int         HI_ADDR_BIT = 3;
  localparam int         KEEP_W   = 3;
  localparam int         KEEP_LSB = 2;

  typedef enum logic [2:0] {
    XS_CMD,
    XS_ADDR,
    XS_WDATA,
    XS_RDATA,
    XS_SWR,
    XS_SRD,
    XS_IDLE
  } xfer_st_t;
endpackage

// File: rtl/sermem_front.sv
module sermem_front #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_begin,
  output logic sel_end,
  output logic desel,
  output logic held,
  output logic si_s,
  output logic wp_s,
  output logic hold_err
);
  localparam int PIN_N = 5;
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b10110; // {wp, si, hold, cs, sck}

  logic [PIN_N-1:0] pipe [SYNC_N];
  logic sck_s, cs_s, hold_s;
  logic sck_p, hold_p, desel_q, hold_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_N; i++) pipe[i] <= PIN_IDLE;
    end else begin
      pipe[0] <= {wp_n, si, hold_n, cs_n, sck};
      for (int i = 1; i < SYNC_N; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign {wp_s, si_s, hold_s, cs_s, sck_s} = pipe[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p   <= 1'b0;
      hold_p  <= 1'b1;
      desel_q <= 1'b1;
      hold_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sck_p  <= sck_s;
      hold_p <= hold_s;
      err_q  <= 1'b0;
      if (!hold_q) desel_q <= cs_s;
      if (desel_q) begin
        hold_q <= 1'b0;
      end else if (hold_s != hold_p) begin
        if (!sck_s) hold_q <= !hold_s;
        else        err_q  <= 1'b1;
      end
    end
  end

  assign sck_rise  = sck_s && !sck_p && !desel_q && !hold_q;
  assign sck_fall  = !sck_s && sck_p && !desel_q && !hold_q;
  assign sel_begin = desel_q && !cs_s && !hold_q;
  assign sel_end   = !desel_q && cs_s && !hold_q;
  assign desel     = desel_q;
  assign held      = hold_q;
  assign hold_err  = err_q;

  a_r9_err_keeps_hold: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $stable(hold_q));
  a_r8_cs_frozen: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> $stable(desel_q));
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/sermem_core.sv
module sermem_core
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel_begin,
  input  logic              sel_end,
  input  logic              desel,
  input  logic              held,
  input  logic              si_s,
  input  logic              wp_s,
  input  logic [7:0]        rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              so,
  output logic              so_oe
);
  localparam logic [7:0] HI_MASK = 8'(1 << HI_ADDR_BIT);

  xfer_st_t          st;
  logic [2:0]        bcnt;
  logic [6:0]        ish, osh;
  logic [ADDR_W-1:0] addr;
  logic              rd_mode, wel, wel_drop;
  logic [KEEP_W-1:0] keep;
  logic              so_q, oe_q, so_oe_q;

  logic [7:0] byte_in, sr_byte, src, cmd_lo;
  logic       byte_done, out_phase;

  assign byte_in   = {ish, si_s};
  assign byte_done = sck_rise && (bcnt == 3'd7);
  assign cmd_lo    = byte_in & ~HI_MASK;
  assign out_phase = (st == XS_RDATA) || (st == XS_SRD);

  always_comb begin
    sr_byte = '0;
    sr_byte[KEEP_LSB +: KEEP_W] = keep;
    sr_byte[1] = wel;
  end

  assign src       = (st == XS_SRD) ? sr_byte : rdata;
  assign mem_we    = byte_done && (st == XS_WDATA) && wel && wp_s;
  assign mem_addr  = addr;
  assign mem_wdata = byte_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= XS_IDLE;
      bcnt     <= '0;
      ish      <= '0;
      osh      <= '0;
      addr     <= '0;
      rd_mode  <= 1'b0;
      wel      <= 1'b0;
      wel_drop <= 1'b0;
      keep     <= '0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
      so_oe_q  <= 1'b0;
    end else begin
      so_oe_q <= oe_q && !held && !desel;
      if (sel_begin) begin
        st       <= XS_CMD;
        bcnt     <= '0;
        oe_q     <= 1'b0;
        wel_drop <= 1'b0;
      end else if (sel_end) begin
        st       <= XS_IDLE;
        oe_q     <= 1'b0;
        wel_drop <= 1'b0;
        if (wel_drop) wel <= 1'b0;
      end else begin
        if (sck_rise) begin
          ish  <= {ish[5:0], si_s};
          bcnt <= bcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            XS_CMD: begin
              if (byte_in == CMD_WREN) begin
                wel <= 1'b1;
                st  <= XS_IDLE;
              end else if (byte_in == CMD_WRDI) begin
                wel_drop <= 1'b1;
                st       <= XS_IDLE;
              end else if (byte_in == CMD_RDSR) begin
                st <= XS_SRD;
              end else if (byte_in == CMD_WRSR) begin
                st <= XS_SWR;
              end else if (cmd_lo == CMD_READ || cmd_lo == CMD_WRITE) begin
                addr[ADDR_W-1] <= byte_in[HI_ADDR_BIT];
                rd_mode        <= (cmd_lo == CMD_READ);
                st             <= XS_ADDR;
              end else begin
                st <= XS_IDLE;
              end
            end
            XS_ADDR: begin
              addr[7:0] <= byte_in;
              st        <= rd_mode ? XS_RDATA : XS_WDATA;
            end
            XS_WDATA: begin
              addr     <= addr + 1'b1;
              wel_drop <= 1'b1;
            end
            XS_RDATA: addr <= addr + 1'b1;
            XS_SWR: begin
              if (wel && wp_s) keep <= byte_in[KEEP_LSB +: KEEP_W];
              wel_drop <= 1'b1;
              st       <= XS_IDLE;
            end
            default: ;
          endcase
        end
        if (sck_fall && out_phase) begin
          oe_q <= 1'b1;
          if (bcnt == 3'd0) begin
            so_q <= src[7];
            osh  <= src[6:0];
          end else begin
            so_q <= osh[6];
            osh  <= {osh[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = so_oe_q;

  a_r2_so_after_fall: assert property (@(posedge clk) disable iff (rst)
    (so_q != $past(so_q)) |-> $past(sck_fall));
  a_r8_state_frozen: assert property (@(posedge clk) disable iff (rst)
    held |=> ($stable(addr) && $stable(bcnt) && $stable(st)));
  a_r3_addr_wraps: assert property (@(posedge clk) disable iff (rst)
    (byte_done && (st == XS_RDATA || st == XS_WDATA) && !sel_begin && !sel_end)
      |=> (addr == $past(addr) + 1'b1));
  a_r7_keep_protected: assert property (@(posedge clk) disable iff (rst)
    !wp_s |=> $stable(keep));
  a_r5_keep_needs_wel: assert property (@(posedge clk) disable iff (rst)
    !wel |=> $stable(keep));
  a_r10_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
    desel |=> !so_oe_q);
endmodule

// File: rtl/spi_nvmem_target.sv
module spi_nvmem_target #(
  parameter int ADDR_W = 9,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe,
  output logic hold_err
);
  logic sck_rise, sck_fall, sel_begin, sel_end, desel, held, si_s, wp_s;
  logic mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  sermem_front #(.SYNC_N(SYNC_N)) front_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .si(si), .wp_n(wp_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_begin(sel_begin), .sel_end(sel_end), .desel(desel), .held(held),
    .si_s(si_s), .wp_s(wp_s), .hold_err(hold_err)
  );

  sermem_core #(.ADDR_W(ADDR_W)) core_i (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_begin(sel_begin), .sel_end(sel_end), .desel(desel), .held(held),
    .si_s(si_s), .wp_s(wp_s), .rdata(mem_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .so(so), .so_oe(so_oe)
  );

  sermem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) array_i (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
    .rdata(mem_rdata)
  );
endmodule

// File: tb/spi_nvmem_target_tb.sv
module spi_nvmem_target_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, hold_err;
  int checks = 0;
  int errs = 0;
  int err_pulses = 0;

  always #4 clk = ~clk;

  spi_nvmem_target dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .si(si), .wp_n(wp_n), .so(so), .so_oe(so_oe), .hold_err(hold_err)
  );

  always @(posedge clk) if (hold_err) err_pulses++;

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o);
    si = b;
    waitn(HALF);
    o = so;
    sck = 1'b1;
    waitn(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      sbit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    waitn(HALF);
  endtask

  task automatic unsel();
    waitn(HALF);
    cs_n = 1'b1;
    waitn(2 * HALF);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); unsel();
  endtask

  task automatic read_sr(output logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, v); unsel();
  endtask

  task automatic write_sr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); unsel();
  endtask

  task automatic addr_phase(input logic [7:0] op, input logic [8:0] a);
    logic [7:0] d;
    xfer(op | {4'b0, a[8], 3'b0}, d);
    xfer(a[7:0], d);
  endtask

  task automatic rd1(input logic [8:0] a, output logic [7:0] v);
    logic [7:0] d;
    sel(); addr_phase(8'h03, a); xfer(8'h00, v); unsel();
    d = v;
  endtask

  task automatic t_reset();
    chk("R10 so_oe after reset", {7'b0, so_oe}, 8'h00);
    chk("R9 hold_err after reset", {7'b0, hold_err}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    one_cmd(8'h06); read_sr(v); chk("R5 WREN sets latch", v, 8'h02);
    one_cmd(8'h04); read_sr(v); chk("R5 WRDI clears latch", v, 8'h00);
    write_sr(8'hFF); read_sr(v); chk("R5 WRSR refused without latch", v, 8'h00);
    one_cmd(8'h06); write_sr(8'hFF); read_sr(v);
    chk("R6 WRSR loads bits 4..2 and clears latch", v, 8'h1C);
  endtask

  task automatic t_write_wrap();
    logic [7:0] d, v0, v1, v2;
    one_cmd(8'h06);
    sel(); addr_phase(8'h02, 9'h1FE);
    xfer(8'hA5, d); xfer(8'h3C, d); xfer(8'h96, d);
    chk("R10 so_oe low during write", {7'b0, so_oe}, 8'h00);
    unsel();
    sel(); addr_phase(8'h03, 9'h1FE);
    xfer(8'h00, v0); xfer(8'h00, v1); xfer(8'h00, v2); unsel();
    chk("R3 read 0x1FE", v0, 8'hA5);
    chk("R3 read 0x1FF", v1, 8'h3C);
    chk("R4 write wrapped to 0x000", v2, 8'h96);
    rd1(9'h000, v0); chk("R3 read at 0x000", v0, 8'h96);
    read_sr(v0); chk("R5 latch cleared after write", v0, 8'h1C);
  endtask

  task automatic t_no_wel();
    logic [7:0] d, v;
    sel(); addr_phase(8'h02, 9'h1FE); xfer(8'h55, d); unsel();
    rd1(9'h1FE, v); chk("R5 write refused without latch", v, 8'hA5);
  endtask

  task automatic t_partial();
    logic [7:0] d, v0, v1;
    one_cmd(8'h06);
    sel(); addr_phase(8'h02, 9'h010); xfer(8'h00, d); xfer(8'h77, d); unsel();
    one_cmd(8'h06);
    sel(); addr_phase(8'h02, 9'h010); xfer(8'h11, d);
    for (int i = 0; i < 4; i++) begin
      logic b;
      sbit(i[0], b);
    end
    unsel();
    sel(); addr_phase(8'h03, 9'h010); xfer(8'h00, v0); xfer(8'h00, v1); unsel();
    chk("R4 full byte stored", v0, 8'h11);
    chk("R4 partial byte dropped", v1, 8'h77);
  endtask

  task automatic t_protect();
    logic [7:0] d, v;
    wp_n = 1'b0;
    waitn(4);
    one_cmd(8'h06);
    sel(); addr_phase(8'h02, 9'h010); xfer(8'hEE, d); unsel();
    rd1(9'h010, v); chk("R7 array write refused", v, 8'h11);
    one_cmd(8'h06); write_sr(8'h00); read_sr(v);
    chk("R7 status write refused", v, 8'h1C);
    wp_n = 1'b1;
    waitn(4);
  endtask

  task automatic t_unknown();
    logic [7:0] v;
    sel(); xfer(8'hFF, v); xfer(8'h00, v);
    chk("R1 unknown command gives no output enable", {7'b0, so_oe}, 8'h00);
    unsel();
    read_sr(v); chk("R1 state unchanged after unknown command", v, 8'h1C);
  endtask

  task automatic t_hold();
    logic [7:0] v0, v1;
    sel(); addr_phase(8'h03, 9'h010);
    for (int i = 7; i >= 4; i--) begin
      logic b;
      sbit(1'b0, b);
      v0[i] = b;
    end
    hold_n = 1'b0;
    waitn(12);
    chk("R8 so_oe low during hold", {7'b0, so_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; waitn(HALF); sck = 1'b0; waitn(HALF);
    end
    cs_n = 1'b1; waitn(12); cs_n = 1'b0; waitn(12);
    hold_n = 1'b1;
    waitn(12);
    chk("R8 so_oe back after hold", {7'b0, so_oe}, 8'h01);
    for (int i = 3; i >= 0; i--) begin
      logic b;
      sbit(1'b0, b);
      v0[i] = b;
    end
    xfer(8'h00, v1);
    unsel();
    chk("R8 byte intact across hold", v0, 8'h11);
    chk("R3 next address after hold", v1, 8'h77);
    chk("R10 so_oe low after deselect", {7'b0, so_oe}, 8'h00);
  endtask

  task automatic t_hold_err();
    logic [7:0] v;
    logic b;
    int base;
    base = err_pulses;
    sel();
    for (int i = 0; i < 4; i++) sbit(1'b0, b);
    si = 1'b0;
    waitn(HALF);
    sck = 1'b1;
    waitn(4);
    hold_n = 1'b0;
    waitn(12);
    hold_n = 1'b1;
    waitn(12);
    sck = 1'b0;
    sbit(1'b1, b); sbit(1'b0, b); sbit(1'b1, b);
    xfer(8'h00, v);
    unsel();
    chk("R9 two one-cycle error pulses", 8'(err_pulses - base), 8'h02);
    chk("R9 command unaffected by bad hold", v, 8'h1C);
  endtask

  initial begin
    waitn(5);
    rst = 1'b0;
    waitn(5);
    t_reset();
    t_status();
    t_write_wrap();
    t_no_wel();
    t_partial();
    t_protect();
    t_unknown();
    t_hold();
    t_hold_err();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule